// File: doc/BRIEF.md
# Platform Interrupt Controller with Per-Context Software Interrupts

This block gathers level-sensitive interrupt lines from many sources and presents one interrupt request per processor context. Software gives each source a 3-bit priority. For each context it sets an enable mask and a priority threshold. A context sees a request while an enabled, pending source has a priority above that context's threshold. The handler reads the claim register to learn which source to service. That read also retires the source's pending state. When the handler is done, it writes the same ID back to end service.

Each context also has a software interrupt bit that drives its own output line, so one processor can signal another. A write-only test register produces a single-cycle pulse on a fatal-alert output. All access uses a 32-bit word register bus. A read answers one cycle after it is issued. ID 0 is reserved to mean "nothing pending", so the block holds IDs 1 to `NUM_SRC`. `NUM_SRC` may be at most 255 and defaults to 84. `NUM_CTX` may be at most 16 and defaults to 1.

Top module: `plic_top`

## Requirements
- R1: After reset, every configuration register, pending bit and service flag is zero, and `ctx_irq_o`, `sw_irq_o`, `fatal_alert_o` and `rsp_valid` are low.
- R2: The priority of source ID k is at byte offset 4*k. Only bits [2:0] are stored, and bits [31:3] read as zero. The ID 0 register always reads zero and ignores writes.
- R3: Pending state is read at offset 0x1000 + 4*w. Bit b of word w is ID 32*w+b. These words are read-only. A source becomes pending one clock after its input (`src_i` bit k-1 for ID k) is sampled high while it is not in service.
- R4: `ctx_irq_o[c]` is high exactly when some pending source, enabled for context c, has a priority strictly greater than that context's threshold. A priority of 0 never raises a request.
- R5: A read of the claim register of context c (0x200004 + 0x1000*c) returns the eligible source with the highest priority. On equal priority the lowest ID wins. The read clears that source's pending bit. The read returns 0 when no source is eligible.
- R6: A claimed source stays in service and cannot become pending again, even with its input held high. This lasts until its ID is written to a claim register. After that write it may become pending on the next sampled high input.
- R7: The software interrupt register of context c is at 0x4000000 + 4*c. Bit 0 is stored and drives `sw_irq_o[c]`. Other bits read as zero.
- R8: A write to 0x4004000 with bit 0 set raises `fatal_alert_o` for exactly the next cycle. A write with bit 0 clear gives no pulse. The register reads as zero.
- R9: Reads of unmapped offsets return zero. Writes to unmapped or read-only offsets change no state.
- R10: Every read gives `rsp_valid` high with its data in the following cycle. Writes give no response.
- R11: The enable word w of context c is at 0x2000 + 0x100*c + 4*w, and bit b enables ID 32*w+b. The bit for ID 0 and bits above `NUM_SRC` read as zero. The threshold of context c is at 0x200000 + 0x1000*c, 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Level interrupt inputs; bit k-1 is ID k |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 27 | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ctx_irq_o | output | NUM_CTX | External interrupt request per context |
| sw_irq_o | output | NUM_CTX | Software interrupt per context |
| fatal_alert_o | output | 1 | Single-cycle alert test pulse |

## Verification
The arbitration is tested with four kinds of pattern:
- sources of differing priority, which shows that the highest priority wins;
- two sources tied at the same priority, which shows that the lower ID wins;
- a source whose priority equals the threshold, which shows that the comparison is strict;
- a source at priority zero, which must never raise a request.

Claims are repeated with all inputs held high to show that in-service sources stay blocked until they are completed, and then return once completed. A second context with its own mask and threshold separates per-context state from shared state. Writes to read-only and unmapped offsets are followed by reads to show that nothing changed.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int PRIO_W  = 3;
    localparam int ID_W    = 8;
    localparam int ADDR_W  = 27;
    localparam int MAX_SRC = 255;
    localparam int MAX_CTX = 16;

    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0100;
    localparam logic [31:0] THR_BASE   = 32'h0020_0000;
    localparam logic [31:0] THR_STRIDE = 32'h0000_1000;
    localparam logic [31:0] SWI_BASE   = 32'h0400_0000;
    localparam logic [31:0] ALERT_ADDR = 32'h0400_4000;

    typedef enum logic [2:0] {
        RG_NONE, RG_PRIO, RG_PEND, RG_EN, RG_THR, RG_CLAIM, RG_SWI, RG_ALERT
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [7:0]  word;
        logic [3:0]  ctx;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int nsrc, input int nctx,
                                            input int nwords);
        decode_t     d;
        logic [31:0] ia;
        logic [31:0] off;
        d   = '{region: RG_NONE, word: 8'd0, ctx: 4'd0};
        ia  = {5'd0, a} & ~32'd3;
        off = 32'd0;
        if (ia <= 32'(4 * nsrc)) begin
            d.region = RG_PRIO;
            d.word   = 8'(ia >> 2);
        end else if (ia >= PEND_BASE && ia < PEND_BASE + 32'(4 * nwords)) begin
            d.region = RG_PEND;
            d.word   = 8'((ia - PEND_BASE) >> 2);
        end else if (ia >= EN_BASE && ia < EN_BASE + EN_STRIDE * 32'(nctx)) begin
            off = ia - EN_BASE;
            if (32'(off[7:0] >> 2) < 32'(nwords)) begin
                d.region = RG_EN;
                d.ctx    = 4'(off >> 8);
                d.word   = 8'(off[7:0] >> 2);
            end
        end else if (ia >= THR_BASE && ia < THR_BASE + THR_STRIDE * 32'(nctx)) begin
            off   = ia - THR_BASE;
            d.ctx = 4'(off >> 12);
            if (off[11:0] == 12'h000)      d.region = RG_THR;
            else if (off[11:0] == 12'h004) d.region = RG_CLAIM;
        end else if (ia >= SWI_BASE && ia < SWI_BASE + 32'(4 * nctx)) begin
            d.region = RG_SWI;
            d.ctx    = 4'((ia - SWI_BASE) >> 2);
        end else if (ia == ALERT_ADDR) begin
            d.region = RG_ALERT;
        end
        return d;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter int NID = 85
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NID-1:0] src,
    input  logic [NID-1:0] claim_hit,
    input  logic [NID-1:0] done_hit,
    output logic [NID-1:0] pending,
    output logic [NID-1:0] active
);
    for (genvar k = 0; k < NID; k++) begin : g_src
        if (k == 0) begin : g_reserved
            assign pending[k] = 1'b0;
            assign active[k]  = 1'b0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    pending[k] <= 1'b0;
                    active[k]  <= 1'b0;
                end else if (claim_hit[k]) begin
                    pending[k] <= 1'b0;
                    active[k]  <= 1'b1;
                end else begin
                    if (src[k] && !active[k]) pending[k] <= 1'b1;
                    if (done_hit[k])          active[k]  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/plic_target.sv
module plic_target
    import plic_pkg::*;
#(
    parameter int NID = 85
) (
    input  logic [NID-1:0][PRIO_W-1:0] prio,
    input  logic [NID-1:0]             pending,
    input  logic [NID-1:0]             enable,
    input  logic [PRIO_W-1:0]          thresh,
    output logic [ID_W-1:0]            best_id,
    output logic                       irq
);
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        best_prio = thresh;
        best_id   = '0;
        for (int k = 1; k < NID; k++) begin
            if (pending[k] && enable[k] && prio[k] > best_prio) begin
                best_prio = prio[k];
                best_id   = ID_W'(k);
            end
        end
        irq = (best_id != '0);
    end
endmodule

// File: rtl/plic_top.sv
module plic_top
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 84,
    parameter int NUM_CTX = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_CTX-1:0] ctx_irq_o,
    output logic [NUM_CTX-1:0] sw_irq_o,
    output logic               fatal_alert_o
);
    localparam int NID  = NUM_SRC + 1;
    localparam int NW   = (NID + 31) / 32;
    localparam int PADW = NW * 32;
    localparam int CTXW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NID-1:0][PRIO_W-1:0]     prio_q;
    logic [NUM_CTX-1:0][PADW-1:0]   en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [NUM_CTX-1:0]             swi_q;
    logic [NUM_CTX-1:0][ID_W-1:0]   best_id;
    logic [NID-1:0]                 pend_q, insvc_q, claim_hit, done_hit;
    logic [PADW-1:0]                pend_pad;
    logic [31:0]                    rd_val;
    logic                           rd_req, wr_req;
    logic [CTXW-1:0]                cidx;
    decode_t                        dec;

    function automatic logic [31:0] word_mask(input logic [7:0] w);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) begin
            m[b] = (32'(w) * 32 + 32'(b) > 0) && (32'(w) * 32 + 32'(b) < 32'(NID));
        end
        return m;
    endfunction

    assign dec      = decode_addr(bus_addr, NUM_SRC, NUM_CTX, NW);
    assign cidx     = CTXW'(dec.ctx);
    assign rd_req   = bus_valid && !bus_write;
    assign wr_req   = bus_valid && bus_write;
    assign pend_pad = PADW'(pend_q);

    plic_gateway #(.NID(NID)) u_gate (
        .clk(clk), .rst(rst), .src({src_i, 1'b0}),
        .claim_hit(claim_hit), .done_hit(done_hit),
        .pending(pend_q), .active(insvc_q)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        plic_target #(.NID(NID)) u_tgt (
            .prio(prio_q), .pending(pend_q), .enable(en_q[c][NID-1:0]),
            .thresh(thr_q[c]), .best_id(best_id[c]), .irq(ctx_irq_o[c])
        );
    end

    always_comb begin
        claim_hit = '0;
        done_hit  = '0;
        if (rd_req && dec.region == RG_CLAIM && 32'(best_id[cidx]) < 32'(NID))
            claim_hit[best_id[cidx]] = 1'b1;
        if (wr_req && dec.region == RG_CLAIM && bus_wdata < 32'(NID))
            done_hit[bus_wdata[ID_W-1:0]] = 1'b1;
    end

    always_comb begin
        case (dec.region)
            RG_PRIO:  rd_val = 32'(prio_q[dec.word]);
            RG_PEND:  rd_val = pend_pad[dec.word*32 +: 32];
            RG_EN:    rd_val = en_q[cidx][dec.word*32 +: 32];
            RG_THR:   rd_val = 32'(thr_q[cidx]);
            RG_CLAIM: rd_val = 32'(best_id[cidx]);
            RG_SWI:   rd_val = 32'(swi_q[cidx]);
            default:  rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q        <= '0;
            en_q          <= '0;
            thr_q         <= '0;
            swi_q         <= '0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            fatal_alert_o <= 1'b0;
        end else begin
            rsp_valid     <= rd_req;
            rsp_rdata     <= rd_req ? rd_val : 32'd0;
            fatal_alert_o <= wr_req && dec.region == RG_ALERT && bus_wdata[0];
            if (wr_req) begin
                case (dec.region)
                    RG_PRIO: if (dec.word != 8'd0) prio_q[dec.word] <= bus_wdata[PRIO_W-1:0];
                    RG_EN:   en_q[cidx][dec.word*32 +: 32] <= bus_wdata & word_mask(dec.word);
                    RG_THR:  thr_q[cidx] <= bus_wdata[PRIO_W-1:0];
                    RG_SWI:  swi_q[cidx] <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    assign sw_irq_o = swi_q;

endmodule

// File: rtl/plic_checker.sv
module plic_checker
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 84,
    parameter int NUM_CTX = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               rsp_valid,
    input logic [NUM_CTX-1:0] ctx_irq_o,
    input logic [NUM_CTX-1:0] sw_irq_o,
    input logic               fatal_alert_o,
    input logic [NUM_SRC:0]   pend_q,
    input logic [NUM_SRC:0]   insvc_q
);
    p_irq_needs_pending_r4: assert property (@(posedge clk) disable iff (rst)
        (|ctx_irq_o) |-> (|pend_q));

    p_no_pend_in_service_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q & insvc_q) == '0);

    p_swi_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_irq_o) |-> $past(bus_valid && bus_write));

    p_alert_cause_r8: assert property (@(posedge clk) disable iff (rst)
        fatal_alert_o |-> $past(bus_valid && bus_write &&
                                {5'd0, bus_addr} == ALERT_ADDR && bus_wdata[0]));

    p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(bus_valid && !bus_write));

    p_read_answered_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> rsp_valid);
endmodule

bind plic_top plic_checker #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .ctx_irq_o(ctx_irq_o), .sw_irq_o(sw_irq_o), .fatal_alert_o(fatal_alert_o),
    .pend_q(pend_q), .insvc_q(insvc_q)
);

// File: tb/test_plic_top.sv
module test_plic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 84;
    localparam int NCTX = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_valid = 1'b0, bus_write = 1'b0;
    logic [26:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            rsp_valid, fatal_alert_o;
    logic [31:0]     rsp_rdata;
    logic [NCTX-1:0] ctx_irq_o, sw_irq_o;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    plic_top #(.NUM_SRC(NSRC), .NUM_CTX(NCTX)) i_plic_top (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctx_irq_o(ctx_irq_o),
        .sw_irq_o(sw_irq_o), .fatal_alert_o(fatal_alert_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [26:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [26:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ctx_irq", 32'(ctx_irq_o), 0);
        chk("R1 sw_irq", 32'(sw_irq_o), 0);
        chk("R1 alert", 32'(fatal_alert_o), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        rd(27'h4, 0, "R1 prio1");
        rd(27'h200004, 0, "R1 claim empty");
        rd(27'h1000, 0, "R1 pending");

        // R2 priority field width, ID 0 reserved
        wr(27'h4, 32'hFFFF_FFFF);
        chk("R10 no write response", 32'(rsp_valid), 0);
        rd(27'h4, 7, "R2 prio masked");
        wr(27'h0, 5);
        rd(27'h0, 0, "R2 prio id0");
        wr(27'h4, 0);

        // R9 unmapped and read-only
        rd(27'h1800, 0, "R9 unmapped hole");
        rd(27'h200008, 0, "R9 unmapped ctx gap");
        rd(27'h2200, 0, "R9 absent ctx enable");
        wr(27'h1000, 32'hFFFF_FFFF);
        wr(27'h2200, 32'hFFFF_FFFF);
        rd(27'h1000, 0, "R9 pending write ignored");
        chk("R9 irq after bad writes", 32'(ctx_irq_o), 0);

        // priorities and enables
        wr(27'h4 * 3, 2);
        wr(27'h4 * 5, 5);
        wr(27'h4 * 40, 5);
        wr(27'h4 * 84, 1);
        wr(27'h2000, 32'h29);
        wr(27'h2004, 32'h100);
        wr(27'h2008, 32'hFFFF_FFFF);
        rd(27'h2000, 32'h28, "R11 enable id0 bit");
        rd(27'h2008, 32'h001F_FFFF, "R11 enable top bits");

        // R3 pending from sources
        src_i[2] = 1'b1; src_i[4] = 1'b1; src_i[39] = 1'b1; src_i[83] = 1'b1;
        @(negedge clk);
        rd(27'h1000, 32'h28, "R3 pending w0");
        rd(27'h1004, 32'h100, "R3 pending w1");
        rd(27'h1008, 32'h0010_0000, "R3 pending w2");
        chk("R4 irq ctx0 on", 32'(ctx_irq_o), 32'b01);

        // R4 strict threshold
        wr(27'h200000, 5);
        chk("R4 irq at threshold", 32'(ctx_irq_o), 0);
        rd(27'h200000, 5, "R11 threshold read");
        wr(27'h200000, 4);
        chk("R4 irq above threshold", 32'(ctx_irq_o), 32'b01);

        // R5 claim order, R6 blocking
        rd(27'h200004, 5, "R5 tie lowest id");
        rd(27'h1000, 32'h08, "R6 claimed stays clear");
        rd(27'h200004, 40, "R5 second");
        rd(27'h200004, 0, "R5 none above threshold");
        chk("R4 irq off", 32'(ctx_irq_o), 0);
        wr(27'h200000, 0);
        rd(27'h200004, 3, "R5 higher prio first");
        rd(27'h200004, 84, "R5 last");
        rd(27'h200004, 0, "R5 empty");

        // R6 complete lets source return
        wr(27'h200004, 5);
        @(negedge clk);
        rd(27'h1000, 32'h20, "R6 repending after complete");
        chk("R4 irq after complete", 32'(ctx_irq_o), 32'b01);
        wr(27'h4 * 5, 0);
        chk("R4 prio zero silent", 32'(ctx_irq_o), 0);
        rd(27'h200004, 0, "R5 prio zero not claimed");

        // second context
        wr(27'h4 * 5, 3);
        wr(27'h2100, 32'h20);
        wr(27'h201000, 2);
        chk("R4 both contexts", 32'(ctx_irq_o), 32'b11);
        rd(27'h201004, 5, "R5 ctx1 claim");
        chk("R4 shared pending cleared", 32'(ctx_irq_o), 0);

        // R7 software interrupts
        wr(27'h4000004, 32'hFFFF_FFFF);
        chk("R7 swi ctx1", 32'(sw_irq_o), 32'b10);
        rd(27'h4000004, 1, "R7 swi read");
        wr(27'h4000000, 1);
        chk("R7 swi both", 32'(sw_irq_o), 32'b11);
        wr(27'h4000004, 0);
        chk("R7 swi ctx1 off", 32'(sw_irq_o), 32'b01);

        // R8 alert pulse
        wr(27'h4004000, 1);
        chk("R8 alert pulse", 32'(fatal_alert_o), 1);
        @(negedge clk);
        chk("R8 alert one cycle", 32'(fatal_alert_o), 0);
        wr(27'h4004000, 2);
        chk("R8 no pulse bit0 clear", 32'(fatal_alert_o), 0);
        rd(27'h4004000, 0, "R8 alert reads zero");

        repeat (3) @(negedge clk);
        chk("R10 all reads answered", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule